// File: doc/BRIEF.md
# Free-Region Allocator

This block manages a small table of free memory regions, each held as a base address and a length in words. A client asks for a block of a given size and receives the base address of a region taken from the table. The allocator walks the table one entry per clock and places the request with one of two policies, chosen per request by a mode input. The first policy takes the first region that is large enough. The second walks the whole table and takes the region that leaves the smallest remainder. Only free regions at least as large as the request are considered. Nothing already handed out is moved or taken back.

After a successful placement the chosen region is trimmed from its low end: its base moves up by the request size and its length drops by the same amount. A region trimmed to nothing leaves the table. When no region fits, the request completes with a failure flag. Returning a block puts it back into the table as a new free region in the lowest empty slot, or raises a full error when every slot is in use. While a scan runs the block reports busy and ignores all new requests.

Top module: `region_alloc`

## Requirements
- R1: After reset every table slot is empty, busy, alloc_done, alloc_fail and full_err are low, and any allocation fails.
- R2: A release (free_req with non-zero free_len, sampled while busy is low and alloc_req is low) stores the region in the lowest-indexed empty slot on that clock edge, without raising busy.
- R3: A release arriving when all slots hold regions pulses full_err for one cycle, starting on the edge that samples the release, and leaves the table unchanged.
- R4: A release with free_len equal to zero is ignored and occupies no slot.
- R5: An allocation sampled while busy is low is accepted and busy is high from the next cycle until the completion pulse. While busy is high, alloc_req and free_req are ignored. If alloc_req and free_req arrive together, the allocation is taken and the release is dropped.
- R6: With fit_mode = 0 (first fit) the scan stops at the lowest-indexed slot whose length is at least the request size. When that slot is index k, alloc_done rises k+1 clock edges after the accepting edge.
- R7: With fit_mode = 1 (best fit) all ENTRIES slots are examined and the chosen slot has the smallest length minus request size, with ties going to the lower index. alloc_done rises ENTRIES edges after the accepting edge.
- R8: On success alloc_base holds the chosen region's base as it was before the allocation. That region's base then grows by the request size and its length shrinks by the same amount.
- R9: A region whose length reaches zero leaves the table, and its slot can take a later release.
- R10: When no region fits, or the request size is zero, alloc_fail pulses together with alloc_done after a full scan of ENTRIES edges, and the table is unchanged.
- R11: alloc_done is a single-cycle pulse, and alloc_fail is never high without alloc_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocation request, sampled when busy is low |
| alloc_size | input | LEN_W | Requested size in words |
| fit_mode | input | 1 | 0 = first fit, 1 = best fit |
| free_req | input | 1 | Release request, sampled when busy is low |
| free_base | input | ADDR_W | Base of the region being returned |
| free_len | input | LEN_W | Length of the region being returned |
| busy | output | 1 | High while a scan runs |
| alloc_done | output | 1 | One-cycle completion pulse for an allocation |
| alloc_fail | output | 1 | Pulses with alloc_done when nothing fits |
| alloc_base | output | ADDR_W | Base of the granted region, held until the next success |
| full_err | output | 1 | One-cycle pulse when a release finds no empty slot |

## Verification
Some rules are checked by assertions on every cycle. No stored region is valid with zero length. The table never takes a release and a trim in the same cycle. Every trim lands on a valid region at least as large as the request, and the trimmed base matches the old base plus the size. The completion and failure pulses are properly formed, and busy only drops with a completion. Other behaviour can only be shown by the bench's scenarios: which region each policy picks, the lower-index rule on best-fit ties, the completion latency that reveals the scan position, reuse of emptied slots, and the dropping of requests made while busy, zero-length releases and releases into a full table.

// File: rtl/region_alloc_pkg.sv
// Package: shared types for the free-region allocator.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package region_alloc_pkg;

    typedef enum logic {
        FIT_FIRST = 1'b0,
        FIT_BEST  = 1'b1
    } fit_mode_e;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/region_table.sv
// Module: region_table
// Holds ENTRIES free regions (valid, base, length). It accepts one write per
// cycle: either an insertion into the lowest empty slot, or a trim of a chosen
// slot by a granted size. It raises full_err for one cycle when an insertion
// finds no empty slot.
// Assumes: the caller never requests an insertion and a trim in the same
// cycle, and a trim always names a valid slot that is large enough.
module region_table #(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ins_en,
    input  logic [ADDR_W-1:0]              ins_base,
    input  logic [LEN_W-1:0]               ins_len,
    input  logic                           upd_en,
    input  logic [IDX_W-1:0]               upd_idx,
    input  logic [LEN_W-1:0]               upd_size,
    output logic [ENTRIES-1:0]             ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent_base,
    output logic [ENTRIES-1:0][LEN_W-1:0]  ent_len,
    output logic                           full_err
);

    logic             has_empty;
    logic [IDX_W-1:0] empty_idx;

    // Priority-encode the lowest empty slot.
    always_comb begin
        has_empty = 1'b0;
        empty_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                has_empty = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
    end

    // Apply an insertion or a trim to the table, and flag a failed insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_base  <= '0;
            ent_len   <= '0;
            full_err  <= 1'b0;
        end else begin
            full_err <= 1'b0;
            if (ins_en) begin
                if (has_empty) begin
                    ent_valid[empty_idx] <= 1'b1;
                    ent_base[empty_idx]  <= ins_base;
                    ent_len[empty_idx]   <= ins_len;
                end else begin
                    full_err <= 1'b1;
                end
            end
            if (upd_en) begin
                ent_base[upd_idx] <= ent_base[upd_idx] + ADDR_W'(upd_size);
                ent_len[upd_idx]  <= ent_len[upd_idx] - upd_size;
                if (ent_len[upd_idx] == upd_size) begin
                    ent_valid[upd_idx] <= 1'b0;
                end
            end
        end
    end

    // R9: a stored region never has zero length.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_nonzero
        a_r9_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            ent_valid[g] |-> (ent_len[g] != '0));
    end

    // R5: insertion and trim never share a cycle.
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_en && upd_en));

    // R6: a trim only touches a valid region at least as large as the request.
    a_r6_trim_fits: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (ent_valid[upd_idx] && (ent_len[upd_idx] >= upd_size) && (upd_size != '0)));

    // R8: the trimmed region's base advances by the granted size.
    a_r8_base_moves: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (ent_base[$past(upd_idx)] == $past(ent_base[upd_idx]) + ADDR_W'($past(upd_size))));

endmodule

// File: rtl/fit_scanner.sv
// Module: fit_scanner
// Sequential placement engine. It examines one table slot per clock. In
// first-fit mode it stops at the first slot that fits. In best-fit mode it
// visits every slot and keeps the smallest remainder, with the earlier slot
// winning a tie. On the final edge it issues the trim to the table and
// registers the result.
// Assumes: start is only asserted while busy is low, and the table contents
// do not change while a scan runs.
module fit_scanner
    import region_alloc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [LEN_W-1:0]               start_size,
    input  fit_mode_e                      start_mode,
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_base,
    input  logic [ENTRIES-1:0][LEN_W-1:0]  ent_len,
    output logic                           busy,
    output logic                           done,
    output logic                           fail,
    output logic [ADDR_W-1:0]              res_base,
    output logic                           upd_en,
    output logic [IDX_W-1:0]               upd_idx,
    output logic [LEN_W-1:0]               upd_size
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    scan_state_e      state;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] size_q;
    fit_mode_e        mode_q;
    logic             have_best;
    logic [IDX_W-1:0] best_idx;
    logic [LEN_W-1:0] best_slack;

    logic             cur_fits;
    logic [LEN_W-1:0] cur_slack;
    logic             cur_better;
    logic             ff_hit;
    logic             end_scan;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    // Judge the slot under the cursor and form the winner of the scan so far.
    always_comb begin
        cur_fits   = ent_valid[idx] && (ent_len[idx] >= size_q) && (size_q != '0);
        cur_slack  = ent_len[idx] - size_q;
        cur_better = cur_fits && (!have_best || (cur_slack < best_slack));
        ff_hit     = (mode_q == FIT_FIRST) && cur_fits;
        end_scan   = ff_hit || (idx == LAST_IDX);
        win_valid  = ff_hit || cur_better || have_best;
        win_idx    = (ff_hit || cur_better) ? idx : best_idx;
    end

    // Drive the table trim on the final edge of a successful scan.
    always_comb begin
        busy     = (state == SCAN_RUN);
        upd_en   = busy && end_scan && win_valid;
        upd_idx  = win_idx;
        upd_size = size_q;
    end

    // Step the scan state, track the best candidate and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SCAN_IDLE;
            idx        <= '0;
            size_q     <= '0;
            mode_q     <= FIT_FIRST;
            have_best  <= 1'b0;
            best_idx   <= '0;
            best_slack <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
            res_base   <= '0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                SCAN_IDLE: begin
                    if (start) begin
                        state     <= SCAN_RUN;
                        idx       <= '0;
                        size_q    <= start_size;
                        mode_q    <= start_mode;
                        have_best <= 1'b0;
                    end
                end
                SCAN_RUN: begin
                    if (cur_better) begin
                        have_best  <= 1'b1;
                        best_idx   <= idx;
                        best_slack <= cur_slack;
                    end
                    if (end_scan) begin
                        state <= SCAN_IDLE;
                        done  <= 1'b1;
                        fail  <= !win_valid;
                        if (win_valid) begin
                            res_base <= ent_base[win_idx];
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SCAN_IDLE;
            endcase
        end
    end

    // R11: failure only accompanies a completion.
    a_r11_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R11: completion lasts exactly one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy only drops together with a completion pulse.
    a_r5_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: the cursor stays inside the table while scanning.
    a_r7_cursor_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= LAST_IDX));

endmodule

// File: rtl/region_alloc.sv
// Module: region_alloc (top)
// Free-region allocator. Allocation requests start a table scan. Releases
// insert directly into the table when the block is idle. An allocation wins
// over a release presented in the same cycle, and zero-length releases are
// dropped.
// Assumes: requests are qualified by the caller with busy; anything that
// arrives while busy is high is ignored.
module region_alloc
    import region_alloc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [LEN_W-1:0]  alloc_size,
    input  logic              fit_mode,
    input  logic              free_req,
    input  logic [ADDR_W-1:0] free_base,
    input  logic [LEN_W-1:0]  free_len,
    output logic              busy,
    output logic              alloc_done,
    output logic              alloc_fail,
    output logic [ADDR_W-1:0] alloc_base,
    output logic              full_err
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic                           alloc_go;
    logic                           free_go;
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_base;
    logic [ENTRIES-1:0][LEN_W-1:0]  ent_len;
    logic                           upd_en;
    logic [IDX_W-1:0]               upd_idx;
    logic [LEN_W-1:0]               upd_size;

    // Qualify requests: nothing while busy, allocation first, no empty releases.
    always_comb begin
        alloc_go = alloc_req && !busy;
        free_go  = free_req && !busy && !alloc_req && (free_len != '0);
    end

    region_table #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (free_go),
        .ins_base (free_base),
        .ins_len  (free_len),
        .upd_en   (upd_en),
        .upd_idx  (upd_idx),
        .upd_size (upd_size),
        .ent_valid(ent_valid),
        .ent_base (ent_base),
        .ent_len  (ent_len),
        .full_err (full_err)
    );

    fit_scanner #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (alloc_go),
        .start_size(alloc_size),
        .start_mode(fit_mode_e'(fit_mode)),
        .ent_valid (ent_valid),
        .ent_base  (ent_base),
        .ent_len   (ent_len),
        .busy      (busy),
        .done      (alloc_done),
        .fail      (alloc_fail),
        .res_base  (alloc_base),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_size  (upd_size)
    );

    // R3: a failed insertion never coincides with a running scan.
    a_r3_full_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        full_err |-> !alloc_done);

endmodule

// File: tb/region_alloc_bench.sv
`timescale 1ns/1ps
module region_alloc_bench;

    localparam int ADDR_W  = 16;
    localparam int LEN_W   = 16;
    localparam int ENTRIES = 8;

    typedef struct packed {
        logic        is_alloc;
        logic        mode;
        logic [15:0] a;
        logic [15:0] b;
        logic        exp_err;
        logic [15:0] exp_base;
        logic [3:0]  exp_lat;
    } vec_t;

    localparam int NVEC = 14;
    // Free: a = base, b = length, exp_err = full_err expected.
    // Alloc: a = size, mode 0 first fit / 1 best fit, exp_err = fail expected.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 16'h0100, 16'h0040, 1'b0, 16'h0000, 4'd0},
        '{1'b0, 1'b0, 16'h0200, 16'h0010, 1'b0, 16'h0000, 4'd0},
        '{1'b0, 1'b0, 16'h0300, 16'h0020, 1'b0, 16'h0000, 4'd0},
        '{1'b0, 1'b0, 16'h0400, 16'h0018, 1'b0, 16'h0000, 4'd0},
        '{1'b1, 1'b0, 16'h0018, 16'h0000, 1'b0, 16'h0100, 4'd1},
        '{1'b1, 1'b1, 16'h0018, 16'h0000, 1'b0, 16'h0400, 4'd8},
        '{1'b1, 1'b1, 16'h0010, 16'h0000, 1'b0, 16'h0200, 4'd8},
        '{1'b1, 1'b0, 16'h0020, 16'h0000, 1'b0, 16'h0118, 4'd1},
        '{1'b1, 1'b0, 16'h0030, 16'h0000, 1'b1, 16'h0000, 4'd8},
        '{1'b0, 1'b0, 16'h0500, 16'h0008, 1'b0, 16'h0000, 4'd0},
        '{1'b1, 1'b1, 16'h0008, 16'h0000, 1'b0, 16'h0138, 4'd8},
        '{1'b1, 1'b0, 16'h0008, 16'h0000, 1'b0, 16'h0500, 4'd2},
        '{1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 4'd8},
        '{1'b1, 1'b0, 16'h0001, 16'h0000, 1'b0, 16'h0300, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic [LEN_W-1:0]  alloc_size = '0;
    logic              fit_mode = 1'b0;
    logic              free_req = 1'b0;
    logic [ADDR_W-1:0] free_base = '0;
    logic [LEN_W-1:0]  free_len = '0;
    logic              busy;
    logic              alloc_done;
    logic              alloc_fail;
    logic [ADDR_W-1:0] alloc_base;
    logic              full_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    region_alloc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ENTRIES(ENTRIES)) u_region_alloc (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_size(alloc_size), .fit_mode(fit_mode),
        .free_req(free_req), .free_base(free_base), .free_len(free_len),
        .busy(busy), .alloc_done(alloc_done), .alloc_fail(alloc_fail),
        .alloc_base(alloc_base), .full_err(full_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_free(input logic [15:0] base, input logic [15:0] len,
                           input logic exp_full, input string tag);
        @(negedge clk);
        free_req = 1'b1; free_base = base; free_len = len;
        @(negedge clk);
        free_req = 1'b0;
        check(full_err == exp_full, tag, "full_err after release", int'(full_err), int'(exp_full));
        check(busy == 1'b0, "R2", "busy after release", int'(busy), 0);
    endtask

    task automatic do_alloc(input logic [15:0] size, input logic mode, input logic exp_fail,
                            input logic [15:0] exp_base, input int exp_lat, input string tag);
        int lat;
        @(negedge clk);
        alloc_req = 1'b1; alloc_size = size; fit_mode = mode;
        @(negedge clk);
        alloc_req = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!alloc_done && lat < 40);
        check(alloc_done == 1'b1, tag, "completion seen", int'(alloc_done), 1);
        check(alloc_fail == exp_fail, exp_fail ? "R10" : tag, "fail flag", int'(alloc_fail), int'(exp_fail));
        if (!exp_fail)
            check(alloc_base == exp_base, "R8", "granted base", int'(alloc_base), int'(exp_base));
        check(lat == exp_lat, tag, "completion latency", lat, exp_lat);
        @(negedge clk);
        check(alloc_done == 1'b0 && alloc_fail == 1'b0, "R11", "done is one pulse",
              int'({alloc_done, alloc_fail}), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and empty table
        check({busy, alloc_done, alloc_fail, full_err} == 4'b0, "R1", "outputs after reset",
              int'({busy, alloc_done, alloc_fail, full_err}), 0);
        do_alloc(16'h0001, 1'b0, 1'b1, 16'h0, 8, "R1");

        // Vector table: R2 releases, R6 first fit, R7 best fit, R9 slot reuse
        for (int i = 0; i < NVEC; i++) begin
            if (!VECS[i].is_alloc)
                do_free(VECS[i].a, VECS[i].b, VECS[i].exp_err, "R2");
            else
                do_alloc(VECS[i].a, VECS[i].mode, VECS[i].exp_err, VECS[i].exp_base,
                         int'(VECS[i].exp_lat), VECS[i].mode ? "R7" : "R6");
        end
        // Table now: slot2 = (0x301, 0x1F) only.

        // R5: requests while busy are ignored
        begin
            int lat;
            @(negedge clk);
            alloc_req = 1'b1; alloc_size = 16'h0040; fit_mode = 1'b1;
            @(negedge clk);
            alloc_req = 1'b1; alloc_size = 16'h0001; fit_mode = 1'b0;
            free_req = 1'b1; free_base = 16'h0700; free_len = 16'h0010;
            check(busy == 1'b1, "R5", "busy after accept", int'(busy), 1);
            @(negedge clk);
            alloc_req = 1'b0; free_req = 1'b0;
            lat = 1;
            while (!alloc_done && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            check(lat == ENTRIES && alloc_fail == 1'b1, "R5", "scan latency and fail",
                  lat, ENTRIES);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (alloc_done || busy)
                    check(1'b0, "R5", "ignored alloc started", int'({alloc_done, busy}), 0);
            end
            check(busy == 1'b0, "R5", "idle after ignored requests", int'(busy), 0);
        end

        // R4: zero-length release takes no slot
        do_free(16'h0600, 16'h0000, 1'b0, "R4");
        // Fill the seven empty slots; any stored ignored release would overflow here
        for (int k = 0; k < ENTRIES - 1; k++)
            do_free(16'h0800 + 16'(k * 16), 16'h0004, 1'b0, "R4");
        // R3: release into a full table
        do_free(16'h0900, 16'h0040, 1'b1, "R3");
        do_alloc(16'h0040, 1'b0, 1'b1, 16'h0, ENTRIES, "R3");
        // R7: all short regions tie at zero slack; lowest index (0x800) wins
        do_alloc(16'h0004, 1'b1, 1'b0, 16'h0800, ENTRIES, "R7");
        // R9: emptied slot0 takes the next release; first fit finds it at index 0
        do_free(16'h0A00, 16'h0002, 1'b0, "R9");
        do_alloc(16'h0002, 1'b0, 1'b0, 16'h0A00, 1, "R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule